// File: doc/BRIEF.md
# Byte DMA Channel Pair for a Serial Port

This block moves bytes between one serial peripheral and system memory on two fixed channels. The receive channel takes each byte the peripheral offers and writes it to memory. The transmit channel reads a byte from memory and hands it to the peripheral's transmit holding stage. The channels have no direction or source settings. Each channel has an address pointer and a transfer counter. Software arms a channel by writing a non-zero count.

For each peripheral request the block issues one memory access over a request/acknowledge handshake. When the access completes, the block moves the pointer forward by one byte and lowers the counter by one. An end flag for each channel shows that its counter is zero, and each flag can be passed to the interrupt line through a bit-wise mask. When both channels are ready in the same cycle, the receive side is served first so that incoming data is not lost.

Top module: `bdma_pair`

## Requirements
- R1: After reset both pointers, both counters and the interrupt mask are zero, both end flags read 1, irq_o is low and mem_req_o is low.
- R2: The registers are selected by the 3-bit word index reg_addr_i:
  - 0: receive pointer.
  - 1: receive count, in the low 16 bits.
  - 2: transmit pointer.
  - 3: transmit count, in the low 16 bits.
  - 4: status, read only. Bit 0 is the receive end flag and bit 1 is the transmit end flag.
  - 5: mask set.
  - 6: mask clear.
  - 7: mask read.

  Unused bits read 0. Indices 5 and 6 read 0. A read always returns the current register value, including during a transfer.
- R3: While idle, a channel with a non-zero count and its request high raises mem_req_o in the next cycle. The receive channel asserts mem_we_o with mem_wdata_o equal to the rx_data_i byte sampled at that start. The transmit channel keeps mem_we_o low. mem_addr_o is the channel's pointer.
- R4: mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o stay constant until the cycle in which mem_ack_i is high. That cycle ends the transfer, and mem_req_o is low in the cycle after it.
- R5: In the acknowledge cycle the served channel pulses its strobe: rx_ack_o for receive, or tx_load_o for transmit with tx_data_o equal to mem_rdata_i. At the next edge its pointer goes up by 1 and its count goes down by 1.
- R6: When both channels could start in the same idle cycle, the receive channel is granted.
- R7: A channel whose count is zero starts no transfer. Writing zero to the count stops the channel. A transfer that is already in flight still completes, but it does not change that channel's pointer or count.
- R8: Each end flag is 1 exactly while its channel's count is zero. Writing a non-zero count clears the flag.
- R9: irq_o is the OR of the status bits ANDed with the mask. A 1 written to mask set sets that mask bit, and a 1 written to mask clear clears it. A 0 bit leaves the mask bit unchanged.
- R10: A register write to a pointer or count in the same cycle as that channel's completion update takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Masked end-of-transfer interrupt |
| rx_req_i | input | 1 | Peripheral has a received byte ready |
| rx_data_i | input | 8 | Received byte |
| rx_ack_o | output | 1 | Received byte consumed |
| tx_req_i | input | 1 | Peripheral transmit holding stage is empty |
| tx_data_o | output | 8 | Byte for the transmitter |
| tx_load_o | output | 1 | Load tx_data_o into the transmitter |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 8 | Memory read byte, valid with mem_ack_i |

## Verification
The bench uses the default parameters: 32-bit pointers, 16-bit counters and byte data. It models 256 bytes of memory with an acknowledge latency that it varies from one to three cycles, so the hold-until-acknowledge behaviour is exercised with several wait lengths.

One transmit run starts at pointer 0xFE and crosses a 256-byte boundary. This checks the carry into the upper pointer bits.

A rotating register read on every idle bus cycle compares the live pointer, count, status and mask values with the reference model while transfers are running.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic {CH_RX = 1'b0, CH_TX = 1'b1} ch_e;
  localparam int NUM_CH = 2;
  localparam int REG_IDX_W = 3;
  localparam logic [REG_IDX_W-1:0] IDX_RX_PTR = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_RX_CNT = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_TX_PTR = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_TX_CNT = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_STAT   = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_MSET   = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_MCLR   = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_MASK   = 3'd7;
endpackage

// File: rtl/bdma_chan.sv
module bdma_chan #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_we_i,
  input  logic              cnt_we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              done_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              active_o,
  output logic              end_o
);
  logic adv;
  assign adv      = done_i && (cnt_o != '0);
  assign active_o = (cnt_o != '0);
  assign end_o    = !active_o;

  // write wins over completion update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
      cnt_o <= '0;
    end else begin
      if (ptr_we_i)  ptr_o <= wdata_i;
      else if (adv)  ptr_o <= ptr_o + 1'b1;
      if (cnt_we_i)  cnt_o <= wdata_i[CNT_W-1:0];
      else if (adv)  cnt_o <= cnt_o - 1'b1;
    end
  end

  // R5
  adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ptr_we_i && !cnt_we_i && (cnt_o != '0)
    |=> (ptr_o == $past(ptr_o) + 1'b1) && (cnt_o == $past(cnt_o) - 1'b1));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i && !ptr_we_i && !cnt_we_i |=> $stable(ptr_o) && $stable(cnt_o));

  // R10
  wr_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> cnt_o == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/bdma_arb.sv
module bdma_arb
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH-1:0]             go_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0]             rx_data_i,
  input  logic                          mem_ack_i,
  input  logic [DATA_W-1:0]             mem_rdata_i,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [ADDR_W-1:0]             mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  output logic [NUM_CH-1:0]             done_o,
  output logic [DATA_W-1:0]             tx_data_o
);
  logic              busy_q;
  ch_e               sel_q, pick;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              take;

  // receive first to avoid overrun
  always_comb begin
    take = !busy_q && (go_i != '0);
    pick = go_i[CH_RX] ? CH_RX : CH_TX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sel_q   <= CH_RX;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (!busy_q) begin
      if (take) begin
        busy_q  <= 1'b1;
        sel_q   <= pick;
        addr_q  <= ptr_i[pick];
        wdata_q <= rx_data_i;
      end
    end else if (mem_ack_i) begin
      busy_q <= 1'b0;
    end
  end

  assign mem_req_o   = busy_q;
  assign mem_we_o    = busy_q && (sel_q == CH_RX);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign tx_data_o   = mem_rdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_done
    assign done_o[c] = busy_q && mem_ack_i && (sel_q == ch_e'(c));
  end

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                               && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R4
  req_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o);
  // R6
  rx_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && (go_i == 2'b11) |=> mem_req_o && mem_we_o);
  // R7
  no_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && (go_i == '0) |=> !mem_req_o);
  // R5
  one_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o));
endmodule

// File: rtl/bdma_regs.sv
module bdma_regs
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [REG_IDX_W-1:0]          idx_i,
  input  logic [ADDR_W-1:0]             wdata_i,
  input  logic [NUM_CH-1:0][ADDR_W-1:0] ptr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_i,
  input  logic [NUM_CH-1:0]             end_i,
  output logic [NUM_CH-1:0]             ptr_we_o,
  output logic [NUM_CH-1:0]             cnt_we_o,
  output logic [ADDR_W-1:0]             rdata_o,
  output logic                          irq_o
);
  logic [NUM_CH-1:0] mask_q;

  assign ptr_we_o[CH_RX] = we_i && (idx_i == IDX_RX_PTR);
  assign ptr_we_o[CH_TX] = we_i && (idx_i == IDX_TX_PTR);
  assign cnt_we_o[CH_RX] = we_i && (idx_i == IDX_RX_CNT);
  assign cnt_we_o[CH_TX] = we_i && (idx_i == IDX_TX_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i && idx_i == IDX_MSET) mask_q <= mask_q | wdata_i[NUM_CH-1:0];
    else if (we_i && idx_i == IDX_MCLR) mask_q <= mask_q & ~wdata_i[NUM_CH-1:0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx_i)
      IDX_RX_PTR: rdata_o = ptr_i[CH_RX];
      IDX_RX_CNT: rdata_o[CNT_W-1:0] = cnt_i[CH_RX];
      IDX_TX_PTR: rdata_o = ptr_i[CH_TX];
      IDX_TX_CNT: rdata_o[CNT_W-1:0] = cnt_i[CH_TX];
      IDX_STAT:   rdata_o[NUM_CH-1:0] = end_i;
      IDX_MASK:   rdata_o[NUM_CH-1:0] = mask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(end_i & mask_q);

  // R9
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && idx_i == IDX_MSET |=> (mask_q & $past(wdata_i[NUM_CH-1:0])) == $past(wdata_i[NUM_CH-1:0]));
  // R9
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && idx_i == IDX_MCLR |=> (mask_q & $past(wdata_i[NUM_CH-1:0])) == '0);
  // R9
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (idx_i == IDX_MSET || idx_i == IDX_MCLR)) |=> $stable(mask_q));
endmodule

// File: rtl/bdma_pair.sv
module bdma_pair
  import bdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [REG_IDX_W-1:0] reg_addr_i,
  input  logic [ADDR_W-1:0]    reg_wdata_i,
  output logic [ADDR_W-1:0]    reg_rdata_o,
  output logic                 irq_o,
  input  logic                 rx_req_i,
  input  logic [DATA_W-1:0]    rx_data_i,
  output logic                 rx_ack_o,
  input  logic                 tx_req_i,
  output logic [DATA_W-1:0]    tx_data_o,
  output logic                 tx_load_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [DATA_W-1:0]    mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic [DATA_W-1:0]    mem_rdata_i
);
  logic [NUM_CH-1:0][ADDR_W-1:0] ptr;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
  logic [NUM_CH-1:0]             active, ch_end, done, ptr_we, cnt_we, go, req;

  assign req[CH_RX] = rx_req_i;
  assign req[CH_TX] = tx_req_i;
  assign go         = active & req;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bdma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ptr_we_i (ptr_we[c]),
      .cnt_we_i (cnt_we[c]),
      .wdata_i  (reg_wdata_i),
      .done_i   (done[c]),
      .ptr_o    (ptr[c]),
      .cnt_o    (cnt[c]),
      .active_o (active[c]),
      .end_o    (ch_end[c])
    );
  end

  bdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .idx_i    (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ptr_i    (ptr),
    .cnt_i    (cnt),
    .end_i    (ch_end),
    .ptr_we_o (ptr_we),
    .cnt_we_o (cnt_we),
    .rdata_o  (reg_rdata_o),
    .irq_o    (irq_o)
  );

  bdma_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .ptr_i       (ptr),
    .rx_data_i   (rx_data_i),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done),
    .tx_data_o   (tx_data_o)
  );

  assign rx_ack_o  = done[CH_RX];
  assign tx_load_o = done[CH_TX];

  // R3
  start_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_o && go[CH_RX] |=> mem_addr_o == $past(ptr[CH_RX]));
  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) && !mem_req_o |=> !mem_req_o);
endmodule

// File: tb/bdma_pair_bench.sv
module bdma_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic        rx_req_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_ack_o;
  logic        tx_req_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_load_o;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [7:0]  mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bdma_pair u_bdma_pair (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
    .rx_req_i(rx_req_i), .rx_data_i(rx_data_i), .rx_ack_o(rx_ack_o),
    .tx_req_i(tx_req_i), .tx_data_o(tx_data_o), .tx_load_o(tx_load_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // bench environment state
  logic [7:0] mem [256];
  logic [7:0] rx_src[$];
  logic [7:0] tx_got[$];
  bit         rx_on = 0;
  int         tx_budget = 0;
  int         mem_lat = 1;
  int         wait_n = 0;
  bit         wr_pend = 0, rd_hold = 0;
  logic [2:0] wr_idx, rd_idx, rot = '0;
  logic [31:0] wr_val;

  // reference model
  logic [31:0] m_ptr [2];
  logic [15:0] m_cnt [2];
  logic [1:0]  m_mask;
  bit          m_busy;
  int          m_sel;
  logic [31:0] m_addr;
  logic [7:0]  m_wdata;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ptr[0];
      3'd1: return {16'h0, m_cnt[0]};
      3'd2: return m_ptr[1];
      3'd3: return {16'h0, m_cnt[1]};
      3'd4: return {30'h0, m_cnt[1] == 0, m_cnt[0] == 0};
      3'd7: return {30'h0, m_mask};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr[0] = 0; m_ptr[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_mask = 0; m_busy = 0; m_sel = 0; m_addr = 0; m_wdata = 0;
    end else begin
      bit done;
      logic [15:0] c0, c1;
      done = m_busy && mem_ack_i;
      c0 = m_cnt[0]; c1 = m_cnt[1];
      if (done) begin
        if (m_cnt[m_sel] != 0) begin
          m_ptr[m_sel] = m_ptr[m_sel] + 1;
          m_cnt[m_sel] = m_cnt[m_sel] - 1;
        end
        if (m_sel == 0) void'(rx_src.pop_front());
        else begin
          tx_got.push_back(mem_rdata_i);
          tx_budget--;
        end
      end
      if (reg_we_i) begin
        case (reg_addr_i)
          3'd0: m_ptr[0] = reg_wdata_i;
          3'd1: m_cnt[0] = reg_wdata_i[15:0];
          3'd2: m_ptr[1] = reg_wdata_i;
          3'd3: m_cnt[1] = reg_wdata_i[15:0];
          3'd5: m_mask = m_mask | reg_wdata_i[1:0];
          3'd6: m_mask = m_mask & ~reg_wdata_i[1:0];
          default: ;
        endcase
      end
      if (m_busy) begin
        if (mem_ack_i) m_busy = 0;
      end else if (c0 != 0 && rx_req_i) begin
        m_busy = 1; m_sel = 0; m_addr = m_ptr_pre(0, done); m_wdata = rx_data_i;
      end else if (c1 != 0 && tx_req_i) begin
        m_busy = 1; m_sel = 1; m_addr = m_ptr_pre(1, done);
      end
    end
    #2;
    if (rst_n && !finished) begin
      chk(mem_req_o == m_busy, "R3 mem_req", 32'(mem_req_o), 32'(m_busy));
      if (m_busy) begin
        chk(mem_addr_o == m_addr, "R4 mem_addr", mem_addr_o, m_addr);
        chk(mem_we_o == (m_sel == 0), "R3 mem_we", 32'(mem_we_o), 32'(m_sel == 0));
        if (m_sel == 0) chk(mem_wdata_o == m_wdata, "R3 mem_wdata", 32'(mem_wdata_o), 32'(m_wdata));
      end
      chk(irq_o == |(m_read(3'd4) & 32'(m_mask)), "R9 irq", 32'(irq_o), 32'(|(m_read(3'd4) & 32'(m_mask))));
      chk(reg_rdata_o == m_read(reg_addr_i), "R2 live read", reg_rdata_o, m_read(reg_addr_i));
    end
  end

  // pointer before this edge's register write (start samples pre-edge value)
  logic [31:0] ptr_q [2];
  always @(negedge clk) begin
    ptr_q[0] = m_ptr[0];
    ptr_q[1] = m_ptr[1];
  end
  function automatic logic [31:0] m_ptr_pre(input int c, input bit d);
    if (d) return ptr_q[c];  // idle start never coincides with done
    return ptr_q[c];
  endfunction

  // environment drivers
  always @(negedge clk) begin
    mem_ack_i = 0;
    if (mem_req_o) begin
      if (wait_n >= mem_lat) begin
        mem_ack_i = 1;
        wait_n = 0;
        if (mem_we_o) mem[mem_addr_o[7:0]] = mem_wdata_o;
        mem_rdata_i = mem[mem_addr_o[7:0]];
      end else wait_n++;
    end
    rx_req_i  = rx_on && (rx_src.size() > 0);
    rx_data_i = (rx_src.size() > 0) ? rx_src[0] : 8'h00;
    tx_req_i  = tx_budget > 0;
    if (wr_pend) begin
      reg_we_i = 1; reg_addr_i = wr_idx; reg_wdata_i = wr_val; wr_pend = 0;
    end else begin
      reg_we_i = 0; reg_wdata_i = 0;
      if (rd_hold) reg_addr_i = rd_idx;
      else begin reg_addr_i = rot; rot = rot + 1; end
    end
  end

  // strobe checks, between negedge drive and next posedge
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(rx_ack_o == (m_busy && mem_ack_i && m_sel == 0), "R5 rx_ack", 32'(rx_ack_o), 32'(m_busy && mem_ack_i && m_sel == 0));
      chk(tx_load_o == (m_busy && mem_ack_i && m_sel == 1), "R5 tx_load", 32'(tx_load_o), 32'(m_busy && mem_ack_i && m_sel == 1));
      if (tx_load_o) chk(tx_data_o == mem_rdata_i, "R5 tx_data", 32'(tx_data_o), 32'(mem_rdata_i));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    wr_idx = a; wr_val = v; wr_pend = 1;
    while (wr_pend) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_idx = a; rd_hold = 1;
    @(negedge clk); #1;
    v = reg_rdata_o;
    rd_hold = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(posedge clk);

    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 rx ptr", v, 0);
    rd(3'd3, v); chk(v == 0, "R1 tx cnt", v, 0);
    rd(3'd4, v); chk(v == 32'h3, "R1 status", v, 32'h3);
    rd(3'd7, v); chk(v == 0, "R1 mask", v, 0);
    chk(irq_o == 0 && mem_req_o == 0, "R1 outputs", {irq_o, mem_req_o}, 0);

    // R8 arming clears end flag; R3 receive run
    mem_lat = 1;
    wr(3'd0, 32'h10);
    wr(3'd1, 32'd4);
    rd(3'd4, v); chk(v == 32'h2, "R8 rx end clear", v, 32'h2);
    rx_src.push_back(8'hA1); rx_src.push_back(8'hB2);
    rx_src.push_back(8'hC3); rx_src.push_back(8'hD4);
    rx_on = 1;
    repeat (40) @(posedge clk);
    chk(mem[8'h10] == 8'hA1 && mem[8'h13] == 8'hD4, "R3 rx mem", {mem[8'h10], mem[8'h13]}, 16'hA1D4);
    chk(mem[8'h11] == 8'hB2 && mem[8'h12] == 8'hC3, "R3 rx mem mid", {mem[8'h11], mem[8'h12]}, 16'hB2C3);
    rd(3'd0, v); chk(v == 32'h14, "R5 rx ptr", v, 32'h14);
    rd(3'd1, v); chk(v == 0, "R5 rx cnt", v, 0);
    rd(3'd4, v); chk(v[0] == 1, "R8 rx end set", v, 32'h3);

    // R9 mask
    wr(3'd5, 32'h1); chk(irq_o == 1, "R9 irq on", 32'(irq_o), 1);
    wr(3'd5, 32'h0); rd(3'd7, v); chk(v == 32'h1, "R9 set zero", v, 1);
    wr(3'd6, 32'h0); rd(3'd7, v); chk(v == 32'h1, "R9 clr zero", v, 1);
    wr(3'd6, 32'h1); chk(irq_o == 0, "R9 irq off", 32'(irq_o), 0);

    // R2 count width and write-only indices
    rx_on = 0;
    wr(3'd1, 32'hABCD1234);
    rd(3'd1, v); chk(v == 32'h1234, "R2 cnt width", v, 32'h1234);
    rd(3'd5, v); chk(v == 0, "R2 set reads zero", v, 0);
    wr(3'd1, 32'h0);

    // R5 transmit run across 256-byte boundary
    mem_lat = 2;
    mem[8'hFE] = 8'h5A; mem[8'hFF] = 8'hC3; mem[8'h00] = 8'h7E;
    wr(3'd2, 32'hFE);
    tx_budget = 5;
    wr(3'd3, 32'd3);
    repeat (40) @(posedge clk);
    chk(tx_got.size() == 3, "R7 tx count", tx_got.size(), 3);
    if (tx_got.size() == 3)
      chk({tx_got[0], tx_got[1], tx_got[2]} == 24'h5AC37E, "R5 tx bytes",
          {tx_got[0], tx_got[1], tx_got[2]}, 24'h5AC37E);
    rd(3'd2, v); chk(v == 32'h101, "R5 tx ptr carry", v, 32'h101);
    chk(tx_budget == 2, "R7 tx stopped", tx_budget, 2);
    tx_budget = 0;

    // R6 both ready together
    wr(3'd0, 32'h20);
    wr(3'd2, 32'h60);
    wr(3'd1, 32'd2);
    wr(3'd3, 32'd2);
    rx_src.push_back(8'h11); rx_src.push_back(8'h22);
    rx_on = 1; tx_budget = 2;
    @(posedge clk); #2;
    while (!mem_req_o) begin @(posedge clk); #2; end
    chk(mem_we_o == 1 && mem_addr_o == 32'h20, "R6 rx first", {mem_we_o, mem_addr_o[7:0]}, 9'h120);
    repeat (40) @(posedge clk);
    rd(3'd4, v); chk(v == 32'h3, "R8 both done", v, 32'h3);
    tx_budget = 0;

    // R7 stop by writing zero
    mem_lat = 3;
    rx_on = 0;
    wr(3'd0, 32'h80);
    wr(3'd1, 32'd10);
    for (int i = 0; i < 6; i++) rx_src.push_back(8'(8'h40 + i));
    rx_on = 1;
    repeat (9) @(posedge clk);
    wr(3'd1, 32'd0);
    repeat (30) @(posedge clk);
    rd(3'd1, v); chk(v == 0, "R7 cnt zero", v, 0);
    chk(rx_src.size() > 0, "R7 no further rx", rx_src.size(), 1);
    chk(mem_req_o == 0, "R7 idle", 32'(mem_req_o), 0);

    repeat (5) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule